// File: doc/BRIEF.md
# Channel Command Stream Decoder

This block sits between a command-buffer fetch unit and a group of engines on one channel. It consumes a stream of 32-bit words over a valid/ready handshake. Each word is either a header or a data word. A header picks the engine class, a register offset and a transfer mode. The data words that follow become register writes on a single output port, which carries the class, the offset and the data.

For an engine class, the block keeps a small method latch. A write to the method-select register stores a method number. A later write to the method-data register produces a one-cycle method dispatch, which carries the stored number and the write data. A write to the increment-syncpoint register of an engine class produces a one-cycle increment pulse. The pulse's index is the low 8 bits of the write data. Header modes that are not defined set a sticky error flag, and the word is dropped.

Top module: `chan_cmd_decoder`

## Requirements
- R1: A header word is decoded as follows: mode in bits 31:28, register offset in bits 27:16, value field in bits 15:0. The mode codes are 0 set-class, 1 counted incrementing, 2 counted non-incrementing, 3 mask and 4 immediate.
- R2: A set-class header loads the offset and takes the new class from value bits 15:6. It takes value bits 5:0 as a pending write mask, and it produces no write itself.
- R3: A counted incrementing header takes the value field as a word count. Each following data word is written to the current offset, after which the offset increases by one, wrapping modulo 4096.
- R4: A counted non-incrementing header writes every one of its data words to the header's offset.
- R5: A mask header loads a 16-bit mask. Each data word goes to the offset plus the index of the lowest set mask bit, and that bit is then cleared, until the mask is empty.
- R6: An immediate header writes the low 12 bits of its value field, zero-extended, to its own offset in the class already selected. No data words follow it.
- R7: A word counts as a header only when both the pending count and the pending mask are zero. A pending mask is consumed before a pending count, and the two are never pending together.
- R8: For an engine class (0xF0 or 0x5D by default), a write to offset 0x010 latches a method number. A later write to offset 0x011 pulses mth_valid together with that write, carrying the latched number and the write data. Writes in the host class never dispatch.
- R9: A write in an engine class to offset 0x000 pulses sp_incr together with that write, and sp_index equals data bits 7:0. The same write in the host class gives no pulse.
- R10: A header whose mode is 5 to 15 sets err_flag, which stays set until reset. The word produces no write and is not taken as data; the next word is decoded as a header.
- R11: After reset the selected class is the host class (0x001), nothing is pending, in_ready is high and every output pulse is low.
- R12: While wr_valid is high and wr_ready is low, in_ready is low and the write fields hold steady. A write is presented in the cycle after its word is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Command word present |
| in_data | input | 32 | Command word |
| in_ready | output | 1 | Word accepted at this edge when in_valid is also high |
| wr_valid | output | 1 | Register write pending on the output |
| wr_ready | input | 1 | Consumer takes the write |
| wr_class | output | 10 | Class that owns the written register |
| wr_offset | output | 12 | Register offset |
| wr_data | output | 32 | Write data |
| mth_valid | output | 1 | One-cycle method dispatch |
| mth_class | output | 10 | Class of the dispatch |
| mth_method | output | 32 | Latched method number |
| mth_arg | output | 32 | Method argument |
| sp_incr | output | 1 | One-cycle syncpoint increment |
| sp_index | output | 8 | Syncpoint index |
| err_flag | output | 1 | Sticky bad-mode flag |

## Verification
The bench builds the block with its default parameters: host class 0x001, two engine classes 0xF0 and 0x5D, method-select at 0x010, method-data at 0x011 and syncpoint at 0x000. With these values one short stream covers several cases. A set-class header that also opens a masked burst lands on the method-select and method-data registers, so the method dispatch can be checked directly. A counted burst that starts at offset 0xFFF wraps onto the syncpoint register, which checks the offset wrap and the pulse with one stimulus. Back-pressure is checked in directed tests by holding wr_ready low in the middle of a counted burst.

// File: rtl/chan_cmd_pkg.sv
package chan_cmd_pkg;

    localparam int WORD_W = 32;
    localparam int MODE_W = 4;
    localparam int OFF_W  = 12;
    localparam int VAL_W  = 16;
    localparam int CLS_W  = 10;
    localparam int SMSK_W = 6;   // mask bits carried by a set-class header
    localparam int IMM_W  = 12;  // immediate payload width
    localparam int SP_W   = 8;

    localparam int MODE_LSB = WORD_W - MODE_W;
    localparam int OFF_LSB  = MODE_LSB - OFF_W;

    typedef enum logic [MODE_W-1:0] {
        MODE_CLASS = 4'd0,
        MODE_INCR  = 4'd1,
        MODE_FIXED = 4'd2,
        MODE_MASK  = 4'd3,
        MODE_IMM   = 4'd4
    } mode_e;

    typedef struct packed {
        logic [MODE_W-1:0] mode;
        logic [OFF_W-1:0]  off;
        logic [VAL_W-1:0]  val;
    } hdr_t;

    typedef struct packed {
        logic [CLS_W-1:0]  cls;
        logic [OFF_W-1:0]  off;
        logic [VAL_W-1:0]  cnt;
        logic [VAL_W-1:0]  msk;
        logic              incr;
        logic              err;
        logic              wr_vld;
        logic [CLS_W-1:0]  wr_cls;
        logic [OFF_W-1:0]  wr_off;
        logic [WORD_W-1:0] wr_dat;
        logic              mth_vld;
        logic [CLS_W-1:0]  mth_cls;
        logic [WORD_W-1:0] mth_num;
        logic [WORD_W-1:0] mth_arg;
        logic              sp_vld;
        logic [SP_W-1:0]   sp_idx;
    } st_t;

endpackage

// File: rtl/cmd_hdr_decode.sv
module cmd_hdr_decode
    import chan_cmd_pkg::*;
(
    input  logic [WORD_W-1:0] word,
    output hdr_t              hdr,
    output logic              is_class,
    output logic              is_count,
    output logic              is_incr,
    output logic              is_mask,
    output logic              is_imm,
    output logic              is_bad
);
    always_comb begin
        hdr.mode = word[WORD_W-1:MODE_LSB];
        hdr.off  = word[MODE_LSB-1:OFF_LSB];
        hdr.val  = word[VAL_W-1:0];

        is_class = (hdr.mode == MODE_CLASS);
        is_incr  = (hdr.mode == MODE_INCR);
        is_count = (hdr.mode == MODE_INCR) || (hdr.mode == MODE_FIXED);
        is_mask  = (hdr.mode == MODE_MASK);
        is_imm   = (hdr.mode == MODE_IMM);
        is_bad   = !(is_class || is_count || is_mask || is_imm);
    end
endmodule

// File: rtl/cmd_lsb_find.sv
module cmd_lsb_find #(
    parameter int W = 16,
    localparam int IW = (W > 1) ? $clog2(W) : 1
) (
    input  logic [W-1:0]  vec,
    output logic [IW-1:0] idx,
    output logic          any
);
    always_comb begin
        idx = '0;
        for (int i = W - 1; i >= 0; i--) begin
            if (vec[i]) idx = IW'(i);
        end
        any = |vec;
    end
endmodule

// File: rtl/cmd_method_latch.sv
module cmd_method_latch #(
    parameter int OFF_W = 12,
    parameter int DAT_W = 32,
    parameter logic [OFF_W-1:0] SEL_OFF = 12'h010,
    parameter logic [OFF_W-1:0] DAT_OFF = 12'h011
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [OFF_W-1:0] wr_off,
    input  logic [DAT_W-1:0] wr_data,
    output logic             dispatch,
    output logic [DAT_W-1:0] method
);
    logic [DAT_W-1:0] method_d, method_q;

    always_comb begin
        method_d = method_q;
        if (wr_en && (wr_off == SEL_OFF)) method_d = wr_data;
        dispatch = wr_en && (wr_off == DAT_OFF);
        method   = method_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) method_q <= '0;
        else        method_q <= method_d;
    end
endmodule

// File: rtl/chan_cmd_decoder.sv
module chan_cmd_decoder
    import chan_cmd_pkg::*;
#(
    parameter logic [CLS_W-1:0] HOST_CLASS = 10'h001,
    parameter int NUM_ENG = 2,
    parameter logic [NUM_ENG*CLS_W-1:0] ENG_CLASS = {10'h05D, 10'h0F0},
    parameter logic [OFF_W-1:0] SEL_OFF = 12'h010,
    parameter logic [OFF_W-1:0] DAT_OFF = 12'h011,
    parameter logic [OFF_W-1:0] SP_OFF  = 12'h000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [WORD_W-1:0] in_data,
    output logic              in_ready,
    output logic              wr_valid,
    input  logic              wr_ready,
    output logic [CLS_W-1:0]  wr_class,
    output logic [OFF_W-1:0]  wr_offset,
    output logic [WORD_W-1:0] wr_data,
    output logic              mth_valid,
    output logic [CLS_W-1:0]  mth_class,
    output logic [WORD_W-1:0] mth_method,
    output logic [WORD_W-1:0] mth_arg,
    output logic              sp_incr,
    output logic [SP_W-1:0]   sp_index,
    output logic              err_flag
);
    localparam int IDX_W = $clog2(VAL_W);

    st_t st_d, st_q;

    hdr_t hdr;
    logic h_class, h_count, h_incr, h_mask, h_imm, h_bad;
    logic [IDX_W-1:0] lsb_idx;
    logic lsb_any;

    logic accept;
    logic path_mask, path_cnt, path_hdr;
    logic w_fire;
    logic [OFF_W-1:0]  w_off;
    logic [WORD_W-1:0] w_dat;

    logic [NUM_ENG-1:0] eng_wr, eng_disp;
    logic [WORD_W-1:0]  eng_method [NUM_ENG];
    logic               eng_any;

    cmd_hdr_decode u_hdr (
        .word(in_data), .hdr(hdr), .is_class(h_class), .is_count(h_count),
        .is_incr(h_incr), .is_mask(h_mask), .is_imm(h_imm), .is_bad(h_bad)
    );

    cmd_lsb_find #(.W(VAL_W)) u_lsb (
        .vec(st_q.msk), .idx(lsb_idx), .any(lsb_any)
    );

    // word classification and the write it produces
    always_comb begin
        in_ready  = !st_q.wr_vld || wr_ready;
        accept    = in_valid && in_ready;
        path_mask = lsb_any;
        path_cnt  = !lsb_any && (st_q.cnt != '0);
        path_hdr  = !path_mask && !path_cnt;
        w_fire    = 1'b0;
        w_off     = st_q.off;
        w_dat     = in_data;
        if (accept) begin
            if (path_mask) begin
                w_fire = 1'b1;
                w_off  = st_q.off + OFF_W'(lsb_idx);
            end else if (path_cnt) begin
                w_fire = 1'b1;
            end else if (h_imm) begin
                w_fire = 1'b1;
                w_off  = hdr.off;
                w_dat  = WORD_W'(hdr.val[IMM_W-1:0]);
            end
        end
    end

    generate
        for (genvar g = 0; g < NUM_ENG; g++) begin : g_eng
            assign eng_wr[g] = w_fire && (st_q.cls == ENG_CLASS[g*CLS_W +: CLS_W]);
            cmd_method_latch #(
                .OFF_W(OFF_W), .DAT_W(WORD_W), .SEL_OFF(SEL_OFF), .DAT_OFF(DAT_OFF)
            ) u_latch (
                .clk(clk), .rst_n(rst_n), .wr_en(eng_wr[g]), .wr_off(w_off),
                .wr_data(w_dat), .dispatch(eng_disp[g]), .method(eng_method[g])
            );
        end
    endgenerate

    assign eng_any = |eng_wr;

    // next-state computation
    always_comb begin
        st_d         = st_q;
        st_d.mth_vld = 1'b0;
        st_d.sp_vld  = 1'b0;
        if (st_q.wr_vld && wr_ready) st_d.wr_vld = 1'b0;

        if (accept) begin
            if (path_mask) begin
                st_d.msk = st_q.msk & (st_q.msk - 1'b1);
            end else if (path_cnt) begin
                st_d.cnt = st_q.cnt - 1'b1;
                if (st_q.incr) st_d.off = st_q.off + 1'b1;
            end else if (path_hdr) begin
                if (h_class) begin
                    st_d.off = hdr.off;
                    st_d.cls = hdr.val[VAL_W-1:SMSK_W];
                    st_d.msk = VAL_W'(hdr.val[SMSK_W-1:0]);
                end else if (h_count) begin
                    st_d.off  = hdr.off;
                    st_d.cnt  = hdr.val;
                    st_d.incr = h_incr;
                end else if (h_mask) begin
                    st_d.off = hdr.off;
                    st_d.msk = hdr.val;
                end else if (h_imm) begin
                    st_d.off = hdr.off;
                end else if (h_bad) begin
                    st_d.err = 1'b1;
                end
            end
        end

        if (w_fire) begin
            st_d.wr_vld  = 1'b1;
            st_d.wr_cls  = st_q.cls;
            st_d.wr_off  = w_off;
            st_d.wr_dat  = w_dat;
            st_d.mth_vld = |eng_disp;
            st_d.mth_cls = st_q.cls;
            st_d.mth_arg = w_dat;
            for (int i = 0; i < NUM_ENG; i++) begin
                if (eng_disp[i]) st_d.mth_num = eng_method[i];
            end
            st_d.sp_vld = eng_any && (w_off == SP_OFF);
            st_d.sp_idx = w_dat[SP_W-1:0];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q     <= '0;
            st_q.cls <= HOST_CLASS;
        end else begin
            st_q <= st_d;
        end
    end

    assign wr_valid   = st_q.wr_vld;
    assign wr_class   = st_q.wr_cls;
    assign wr_offset  = st_q.wr_off;
    assign wr_data    = st_q.wr_dat;
    assign mth_valid  = st_q.mth_vld;
    assign mth_class  = st_q.mth_cls;
    assign mth_method = st_q.mth_num;
    assign mth_arg    = st_q.mth_arg;
    assign sp_incr    = st_q.sp_vld;
    assign sp_index   = st_q.sp_idx;
    assign err_flag   = st_q.err;
endmodule

// File: rtl/chan_cmd_decoder_chk.sv
module chan_cmd_decoder_chk
    import chan_cmd_pkg::*;
#(
    parameter logic [OFF_W-1:0] DAT_OFF = 12'h011,
    parameter logic [OFF_W-1:0] SP_OFF  = 12'h000
) (
    input logic              clk,
    input logic              rst_n,
    input logic              in_ready,
    input logic              wr_valid,
    input logic              wr_ready,
    input logic [CLS_W-1:0]  wr_class,
    input logic [OFF_W-1:0]  wr_offset,
    input logic [WORD_W-1:0] wr_data,
    input logic              mth_valid,
    input logic [WORD_W-1:0] mth_arg,
    input logic              sp_incr,
    input logic [SP_W-1:0]   sp_index,
    input logic              err_flag,
    input logic [VAL_W-1:0]  pend_cnt,
    input logic [VAL_W-1:0]  pend_msk
);
    assert_stall_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_valid && !wr_ready) |-> !in_ready);

    assert_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_valid && !wr_ready) |=> (wr_valid && $stable(wr_class)
                                     && $stable(wr_offset) && $stable(wr_data)));

    assert_err_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
        err_flag |=> err_flag);

    assert_pend_excl_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !((pend_cnt != '0) && (pend_msk != '0)));

    assert_dispatch_R8: assert property (@(posedge clk) disable iff (!rst_n)
        mth_valid |-> (wr_valid && (wr_offset == DAT_OFF) && (mth_arg == wr_data)));

    assert_syncpt_R9: assert property (@(posedge clk) disable iff (!rst_n)
        sp_incr |-> (wr_valid && (wr_offset == SP_OFF) && (sp_index == wr_data[SP_W-1:0])));
endmodule

bind chan_cmd_decoder chan_cmd_decoder_chk #(.DAT_OFF(DAT_OFF), .SP_OFF(SP_OFF)) u_chk (
    .clk(clk), .rst_n(rst_n), .in_ready(in_ready), .wr_valid(wr_valid),
    .wr_ready(wr_ready), .wr_class(wr_class), .wr_offset(wr_offset), .wr_data(wr_data),
    .mth_valid(mth_valid), .mth_arg(mth_arg), .sp_incr(sp_incr), .sp_index(sp_index),
    .err_flag(err_flag), .pend_cnt(st_q.cnt), .pend_msk(st_q.msk)
);

// File: tb/chan_cmd_decoder_test.sv
`timescale 1ns/1ps
module chan_cmd_decoder_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [31:0] in_data = '0;
    logic        in_ready;
    logic        wr_valid;
    logic        wr_ready = 1'b1;
    logic [9:0]  wr_class;
    logic [11:0] wr_offset;
    logic [31:0] wr_data;
    logic        mth_valid;
    logic [9:0]  mth_class;
    logic [31:0] mth_method;
    logic [31:0] mth_arg;
    logic        sp_incr;
    logic [7:0]  sp_index;
    logic        err_flag;

    int checks = 0;
    int fails  = 0;

    always #2.5 clk = ~clk;

    chan_cmd_decoder uut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
        .in_ready(in_ready), .wr_valid(wr_valid), .wr_ready(wr_ready),
        .wr_class(wr_class), .wr_offset(wr_offset), .wr_data(wr_data),
        .mth_valid(mth_valid), .mth_class(mth_class), .mth_method(mth_method),
        .mth_arg(mth_arg), .sp_incr(sp_incr), .sp_index(sp_index), .err_flag(err_flag)
    );

    typedef struct packed {
        logic [31:0] word;
        logic        wr;
        logic [9:0]  cls;
        logic [11:0] off;
        logic [31:0] dat;
        logic        mth;
        logic [31:0] num;
        logic        sp;
        logic [7:0]  spi;
        logic [7:0]  req;
    } vec_t;

    localparam int NV = 22;
    localparam vec_t VECS [NV] = '{
        // R3: incrementing header, offset 0x005, three words
        '{32'h1005_0003, 1'b0, 10'h000, 12'h000, 32'h0,         1'b0, 32'h0, 1'b0, 8'h00, 8'd3},
        '{32'hAAAA_0001, 1'b1, 10'h001, 12'h005, 32'hAAAA_0001, 1'b0, 32'h0, 1'b0, 8'h00, 8'd3},
        '{32'h0000_0002, 1'b1, 10'h001, 12'h006, 32'h0000_0002, 1'b0, 32'h0, 1'b0, 8'h00, 8'd3},
        '{32'h0000_0003, 1'b1, 10'h001, 12'h007, 32'h0000_0003, 1'b0, 32'h0, 1'b0, 8'h00, 8'd3},
        // R4: non-incrementing header, offset 0x020, two words
        '{32'h2020_0002, 1'b0, 10'h000, 12'h000, 32'h0,         1'b0, 32'h0, 1'b0, 8'h00, 8'd4},
        '{32'h0000_0011, 1'b1, 10'h001, 12'h020, 32'h0000_0011, 1'b0, 32'h0, 1'b0, 8'h00, 8'd4},
        '{32'h0000_0022, 1'b1, 10'h001, 12'h020, 32'h0000_0022, 1'b0, 32'h0, 1'b0, 8'h00, 8'd4},
        // R5: mask header, bits 0 and 2, offset 0x040
        '{32'h3040_0005, 1'b0, 10'h000, 12'h000, 32'h0,         1'b0, 32'h0, 1'b0, 8'h00, 8'd5},
        '{32'h0000_0033, 1'b1, 10'h001, 12'h040, 32'h0000_0033, 1'b0, 32'h0, 1'b0, 8'h00, 8'd5},
        '{32'h0000_0044, 1'b1, 10'h001, 12'h042, 32'h0000_0044, 1'b0, 32'h0, 1'b0, 8'h00, 8'd5},
        // R6: immediate, payload 0xBCD
        '{32'h4070_ABCD, 1'b1, 10'h001, 12'h070, 32'h0000_0BCD, 1'b0, 32'h0, 1'b0, 8'h00, 8'd6},
        // R2: set-class 0xF0 with mask 0b11 at offset 0x010
        '{32'h0010_3C03, 1'b0, 10'h000, 12'h000, 32'h0,         1'b0, 32'h0, 1'b0, 8'h00, 8'd2},
        // R8: method select then method data
        '{32'h0000_0007, 1'b1, 10'h0F0, 12'h010, 32'h0000_0007, 1'b0, 32'h0, 1'b0, 8'h00, 8'd8},
        '{32'hDEAD_0000, 1'b1, 10'h0F0, 12'h011, 32'hDEAD_0000, 1'b1, 32'h7, 1'b0, 8'h00, 8'd8},
        // R9: immediate to syncpoint register in engine class
        '{32'h4000_0123, 1'b1, 10'h0F0, 12'h000, 32'h0000_0123, 1'b0, 32'h0, 1'b1, 8'h23, 8'd9},
        // R10: bad mode 5, dropped
        '{32'h5000_0000, 1'b0, 10'h000, 12'h000, 32'h0,         1'b0, 32'h0, 1'b0, 8'h00, 8'd10},
        // R3: offset wrap 0xFFF -> 0x000 (lands on syncpoint, R9)
        '{32'h1FFF_0002, 1'b0, 10'h000, 12'h000, 32'h0,         1'b0, 32'h0, 1'b0, 8'h00, 8'd3},
        '{32'h0000_0099, 1'b1, 10'h0F0, 12'hFFF, 32'h0000_0099, 1'b0, 32'h0, 1'b0, 8'h00, 8'd3},
        '{32'h0000_00AA, 1'b1, 10'h0F0, 12'h000, 32'h0000_00AA, 1'b0, 32'h0, 1'b1, 8'hAA, 8'd3},
        // R2: back to host class, no mask
        '{32'h0000_0040, 1'b0, 10'h000, 12'h000, 32'h0,         1'b0, 32'h0, 1'b0, 8'h00, 8'd2},
        // R8: host class write to method-data offset does not dispatch
        '{32'h4011_0055, 1'b1, 10'h001, 12'h011, 32'h0000_0055, 1'b0, 32'h0, 1'b0, 8'h00, 8'd8},
        // R9: host class write to syncpoint offset gives no pulse
        '{32'h4000_0077, 1'b1, 10'h001, 12'h000, 32'h0000_0077, 1'b0, 32'h0, 1'b0, 8'h00, 8'd9}
    };

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual %0h expected %0h", tag, act, exp);
        end
    endtask

    // drive one word for one accepted edge (wr_ready high), sample at next negedge
    task automatic send(input logic [31:0] w);
        @(negedge clk);
        in_valid = 1'b1;
        in_data  = w;
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    initial begin
        repeat (400) @(posedge clk);
        fails++;
        $display("FAIL watchdog actual hung expected done");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R11: reset state
        check("R11 in_ready", 64'(in_ready), 64'd1);
        check("R11 wr_valid", 64'(wr_valid), 64'd0);
        check("R11 pulses", 64'({mth_valid, sp_incr, err_flag}), 64'd0);

        for (int i = 0; i < NV; i++) begin
            string tag;
            send(VECS[i].word);
            tag = $sformatf("R%0d vec%0d", VECS[i].req, i);
            check({tag, " wr_valid"}, 64'(wr_valid), 64'(VECS[i].wr));
            check({tag, " mth_valid"}, 64'(mth_valid), 64'(VECS[i].mth));
            check({tag, " sp_incr"}, 64'(sp_incr), 64'(VECS[i].sp));
            if (VECS[i].wr) begin
                check({tag, " class"}, 64'(wr_class), 64'(VECS[i].cls));
                check({tag, " offset"}, 64'(wr_offset), 64'(VECS[i].off));
                check({tag, " data"}, 64'(wr_data), 64'(VECS[i].dat));
            end
            if (VECS[i].mth) begin
                check({tag, " method"}, 64'(mth_method), VECS[i].num);
                check({tag, " arg"}, 64'(mth_arg), 64'(VECS[i].dat));
                check({tag, " mclass"}, 64'(mth_class), 64'(VECS[i].cls));
            end
            if (VECS[i].sp) check({tag, " spidx"}, 64'(sp_index), 64'(VECS[i].spi));
        end

        // R10: flag is sticky and the next word was decoded as a header (vec 16 onward)
        check("R10 err_flag", 64'(err_flag), 64'd1);

        // R12: back-pressure inside a counted burst
        send(32'h1100_0002);
        @(negedge clk);
        wr_ready = 1'b0;
        send(32'h0000_0A0A);
        check("R12 first write valid", 64'(wr_valid), 64'd1);
        check("R12 first write offset", 64'(wr_offset), 64'h100);
        check("R12 stall", 64'(in_ready), 64'd0);
        in_valid = 1'b1;
        in_data  = 32'h0000_0B0B;
        for (int k = 0; k < 3; k++) begin
            @(negedge clk);
            check("R12 in_ready held low", 64'(in_ready), 64'd0);
            check("R12 data held", 64'(wr_data), 64'h0A0A);
        end
        wr_ready = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
        check("R12 second write data", 64'(wr_data), 64'h0B0B);
        check("R12 second write offset", 64'(wr_offset), 64'h101);
        check("R10 err still set", 64'(err_flag), 64'd1);

        // R7: mask pending with count zero: a mode-looking word is data, not a header
        send(32'h3200_0002);
        send(32'h5000_00EE);
        check("R7 data not header valid", 64'(wr_valid), 64'd1);
        check("R7 data not header offset", 64'(wr_offset), 64'h201);
        check("R7 data not header data", 64'(wr_data), 64'h5000_00EE);
        // R1: immediate after mask drained is a header again
        send(32'h4123_0FFF);
        check("R1 header decode offset", 64'(wr_offset), 64'h123);
        check("R1 header decode data", 64'(wr_data), 64'hFFF);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule